// File: doc/BRIEF.md
# Software Prefetch Touch Buffer

This block serves a software prefetch hint. When a touch command arrives with an address, the block decides whether the hint is worth acting on. If it is, the block issues a request for the whole cache line and counts the beats as they return. When the line is complete it marks a single-entry holding buffer valid, so that the line can later be moved into the data cache.

The hint is dropped with no request and no exception in several cases: the address missed translation, the page does not allow loads, the page is guarded, or the cache is locked or disabled. The held line is discarded in four cases: the cache takes it, any other data cache management command runs, a block-zero command names the same line, or another touch command arrives. A discard during the fill cancels the fill. A completed fill also raises a one-cycle strobe so the cache replacement order treats the line as recently used. Page-table referenced and changed bits have no path out of the block.

Top module: `touch_prefetch_buf`

## Requirements
- R1: A touch is accepted only when `xlat_hit`, `load_ok` are high and `guarded`, `cache_locked`, `cache_disabled` are low. In the cycle after an accepted touch, `fetch_req` is high for exactly one cycle, and `fetch_addr` carries the touch address with its low 5 bits (offset inside a 32-byte line of eight 32-bit words) cleared.
- R2: A touch with a translation miss (`xlat_hit` low) or without load permission (`load_ok` low) completes with no `fetch_req` and leaves `buf_valid` low.
- R3: A touch to a guarded page, or while the cache is locked or disabled, produces no `fetch_req` and leaves `buf_valid` low.
- R4: `buf_valid` goes high in the cycle after the eighth `fill_beat` of a pending fetch, not earlier. `buf_addr` then equals the fetched line address with its low 5 bits cleared.
- R5: `lru_upd` is high for exactly one cycle, the first cycle in which `buf_valid` is high after a fill. It is never high otherwise.
- R6: `moved` while the buffer is valid clears `buf_valid` on the next cycle.
- R7: `cmo_req` clears `buf_valid` and cancels any fetch in progress, so later beats of that fetch never make the buffer valid.
- R8: A block-zero command (`zero_req`) whose address bits above bit 4 match the held or pending line clears the buffer or cancels the fetch. A non-matching block-zero command has no effect.
- R9: Every touch command, accepted or not, discards the current buffer and cancels a pending fetch. An accepted touch starts a new fetch of its own line. A touch takes priority over `cmo_req`, `zero_req` and `moved` in the same cycle.
- R10: `fill_beat` is ignored when no fetch is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| touch_req | input | 1 | Touch command executes this cycle |
| touch_addr | input | ADDR_W | Effective address of the touch |
| xlat_hit | input | 1 | Translation hit for the touch address |
| load_ok | input | 1 | Page permits load access |
| guarded | input | 1 | Page is marked guarded |
| cache_locked | input | 1 | Data cache is locked |
| cache_disabled | input | 1 | Data cache is disabled |
| cmo_req | input | 1 | Another data cache management command executes |
| zero_req | input | 1 | Block-zero command executes |
| zero_addr | input | ADDR_W | Address of the block-zero command |
| moved | input | 1 | Buffer contents have been written into the cache |
| fill_beat | input | 1 | One beat of fetched line data returned |
| fetch_req | output | 1 | One-cycle line fetch request |
| fetch_addr | output | ADDR_W | Line-aligned fetch address |
| buf_valid | output | 1 | Touch buffer holds a complete line |
| buf_addr | output | ADDR_W | Line-aligned address of the held line |
| lru_upd | output | 1 | One-cycle replacement-order update strobe |

## Verification
A wrong beat count inside the block shows at the ports as `buf_valid` and `lru_upd` rising a cycle or more too early or too late, relative to the eighth beat. A pending flag that survives a cancel shows as a buffer that turns valid after a discard, within eight beats. A wrong stored line address shows in `fetch_addr` on the cycle right after the touch and in `buf_addr` once the line completes. It also makes a block-zero to the true line fail to discard the buffer, which shows on the next cycle.

// File: rtl/touch_prefetch_buf.sv
`timescale 1ns/1ps
module touch_prefetch_buf #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int LINE_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              touch_req,
  input  logic [ADDR_W-1:0] touch_addr,
  input  logic              xlat_hit,
  input  logic              load_ok,
  input  logic              guarded,
  input  logic              cache_locked,
  input  logic              cache_disabled,
  input  logic              cmo_req,
  input  logic              zero_req,
  input  logic [ADDR_W-1:0] zero_addr,
  input  logic              moved,
  input  logic              fill_beat,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              buf_valid,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              lru_upd
);
  localparam int OFF_W = $clog2(WORD_BYTES * LINE_WORDS);
  localparam int LA_W  = ADDR_W - OFF_W;
  localparam int CNT_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;

  logic [LA_W-1:0]  line_q;
  logic [CNT_W-1:0] beats_q;
  logic             pend_q, valid_q, req_q, lru_q;

  wire touch_ok  = touch_req & xlat_hit & load_ok & ~guarded & ~cache_locked & ~cache_disabled;
  wire held      = valid_q | pend_q;
  wire zero_hit  = zero_req & held & (zero_addr[ADDR_W-1:OFF_W] == line_q);
  wire kill      = cmo_req | zero_hit | (moved & valid_q);
  wire last_beat = beats_q == CNT_W'(LINE_WORDS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= '0;
      beats_q <= '0;
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
      req_q   <= 1'b0;
      lru_q   <= 1'b0;
    end else begin
      req_q <= touch_ok;
      lru_q <= 1'b0;
      if (touch_req) begin
        valid_q <= 1'b0;
        pend_q  <= touch_ok;
        beats_q <= '0;
        if (touch_ok) line_q <= touch_addr[ADDR_W-1:OFF_W];
      end else if (kill) begin
        valid_q <= 1'b0;
        pend_q  <= 1'b0;
      end else if (pend_q && fill_beat) begin
        beats_q <= beats_q + 1'b1;
        if (last_beat) begin
          pend_q  <= 1'b0;
          valid_q <= 1'b1;
          lru_q   <= 1'b1;
        end
      end
    end
  end

  assign fetch_req  = req_q;
  assign fetch_addr = {line_q, {OFF_W{1'b0}}};
  assign buf_valid  = valid_q;
  assign buf_addr   = {line_q, {OFF_W{1'b0}}};
  assign lru_upd    = lru_q;
endmodule

// File: rtl/touch_prefetch_buf_chk.sv
`timescale 1ns/1ps
module touch_prefetch_buf_chk #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int LINE_WORDS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              touch_req,
  input logic [ADDR_W-1:0] touch_addr,
  input logic              xlat_hit,
  input logic              load_ok,
  input logic              guarded,
  input logic              cache_locked,
  input logic              cache_disabled,
  input logic              cmo_req,
  input logic              moved,
  input logic              fill_beat,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              buf_valid,
  input logic              lru_upd
);
  localparam int OFF_W = $clog2(WORD_BYTES * LINE_WORDS);

  int unsigned beat_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) beat_cnt <= 0;
    else if (touch_req) beat_cnt <= 0;
    else if (fill_beat && beat_cnt < 1000) beat_cnt <= beat_cnt + 1;
  end

  wire refused = touch_req & ~(xlat_hit & load_ok & ~guarded & ~cache_locked & ~cache_disabled);

  AST_REFUSED_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> !fetch_req); // R2
  AST_FETCH_ADDR_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> fetch_addr[ADDR_W-1:OFF_W] == $past(touch_addr[ADDR_W-1:OFF_W]) && fetch_addr[OFF_W-1:0] == '0); // R1
  AST_FULL_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_valid) |-> beat_cnt >= LINE_WORDS); // R4
  AST_LRU_ON_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_valid) |-> lru_upd); // R5
  AST_LRU_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    lru_upd |-> buf_valid); // R5
  AST_MOVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    moved && buf_valid && !touch_req |=> !buf_valid); // R6
  AST_CMO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmo_req && !touch_req |=> !buf_valid); // R7
  AST_TOUCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    touch_req |=> !buf_valid); // R9
endmodule

bind touch_prefetch_buf touch_prefetch_buf_chk #(
  .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .LINE_WORDS(LINE_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .touch_req(touch_req), .touch_addr(touch_addr),
  .xlat_hit(xlat_hit), .load_ok(load_ok), .guarded(guarded),
  .cache_locked(cache_locked), .cache_disabled(cache_disabled),
  .cmo_req(cmo_req), .moved(moved), .fill_beat(fill_beat),
  .fetch_req(fetch_req), .fetch_addr(fetch_addr), .buf_valid(buf_valid),
  .lru_upd(lru_upd)
);

// File: tb/touch_prefetch_buf_tb.sv
`timescale 1ns/1ps
module touch_prefetch_buf_tb;
  localparam int AW = 32;

  logic clk = 0, rst_n = 0;
  logic touch_req = 0, xlat_hit = 0, load_ok = 0, guarded = 0, cache_locked = 0, cache_disabled = 0;
  logic cmo_req = 0, zero_req = 0, moved = 0, fill_beat = 0;
  logic [AW-1:0] touch_addr = '0, zero_addr = '0;
  logic fetch_req, buf_valid, lru_upd;
  logic [AW-1:0] fetch_addr, buf_addr;

  int n_tests = 0, n_fail = 0;
  logic m_valid = 0, m_pend = 0, m_req = 0, m_lru = 0;
  int m_cnt = 0;
  logic [AW-6:0] m_line = '0;

  always #4 clk = ~clk;

  touch_prefetch_buf u_dut (.*);

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] align(logic [AW-1:0] a);
    return {a[AW-1:5], 5'b0};
  endfunction

  task automatic model_step();
    logic ok, held;
    ok = touch_req & xlat_hit & load_ok & ~guarded & ~cache_locked & ~cache_disabled;
    held = m_valid | m_pend;
    m_req = ok;
    m_lru = 0;
    if (touch_req) begin
      m_valid = 0; m_pend = ok; m_cnt = 0;
      if (ok) m_line = touch_addr[AW-1:5];
    end else if (cmo_req || (zero_req && held && zero_addr[AW-1:5] == m_line) || (moved && m_valid)) begin
      m_valid = 0; m_pend = 0;
    end else if (m_pend && fill_beat) begin
      if (m_cnt == 7) begin m_pend = 0; m_valid = 1; m_lru = 1; end
      else m_cnt++;
    end
  endtask

  task automatic compare();
    chk("R1 fetch_req", {31'b0, fetch_req}, {31'b0, m_req});
    if (m_req) chk("R1 fetch_addr", fetch_addr, {m_line, 5'b0});
    chk("R4 buf_valid", {31'b0, buf_valid}, {31'b0, m_valid});
    if (m_valid) chk("R4 buf_addr", buf_addr, {m_line, 5'b0});
    chk("R5 lru_upd", {31'b0, lru_upd}, {31'b0, m_lru});
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    touch_req = 0; cmo_req = 0; zero_req = 0; moved = 0; fill_beat = 0;
    xlat_hit = 1; load_ok = 1; guarded = 0; cache_locked = 0; cache_disabled = 0;
  endtask

  task automatic touch(logic [AW-1:0] a, logic h, logic p, logic g, logic lk, logic d);
    idle();
    touch_req = 1; touch_addr = a; xlat_hit = h; load_ok = p;
    guarded = g; cache_locked = lk; cache_disabled = d;
    tick();
    idle();
  endtask

  task automatic beats(int n);
    for (int i = 0; i < n; i++) begin
      idle(); fill_beat = 1; tick();
    end
    idle();
  endtask

  task automatic fill(logic [AW-1:0] a);
    touch(a, 1, 1, 0, 0, 0);
    beats(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk("R4 reset buf_valid", {31'b0, buf_valid}, 0);
    chk("R1 reset fetch_req", {31'b0, fetch_req}, 0);
    chk("R5 reset lru_upd", {31'b0, lru_upd}, 0);

    touch(32'h2000_0047, 1, 1, 0, 0, 0);
    chk("R1 request raised", {31'b0, fetch_req}, 1);
    chk("R1 aligned address", fetch_addr, 32'h2000_0040);
    beats(1);
    chk("R1 request one cycle", {31'b0, fetch_req}, 0);
    beats(6);
    chk("R4 not valid after 7 beats", {31'b0, buf_valid}, 0);
    beats(1);
    chk("R4 valid after 8 beats", {31'b0, buf_valid}, 1);
    chk("R4 buffer address", buf_addr, 32'h2000_0040);
    chk("R5 lru strobe", {31'b0, lru_upd}, 1);
    tick();
    chk("R5 lru one cycle", {31'b0, lru_upd}, 0);
    beats(1);
    chk("R10 stray beat ignored", {31'b0, buf_valid}, 1);
    chk("R10 no request from stray beat", {31'b0, fetch_req}, 0);

    zero_req = 1; zero_addr = 32'h2000_0060; tick(); idle();
    chk("R8 other line zero ignored", {31'b0, buf_valid}, 1);
    zero_req = 1; zero_addr = 32'h2000_005C; tick(); idle();
    chk("R8 matching zero clears", {31'b0, buf_valid}, 0);

    fill(32'h2000_0100);
    moved = 1; tick(); idle();
    chk("R6 moved clears", {31'b0, buf_valid}, 0);

    fill(32'h2000_0100);
    cmo_req = 1; tick(); idle();
    chk("R7 cmo clears", {31'b0, buf_valid}, 0);
    touch(32'h2000_0200, 1, 1, 0, 0, 0);
    beats(3);
    cmo_req = 1; tick(); idle();
    beats(8);
    chk("R7 cancelled fetch stays invalid", {31'b0, buf_valid}, 0);

    touch(32'h2000_0300, 1, 1, 0, 0, 0);
    beats(2);
    zero_req = 1; zero_addr = 32'h2000_0304; tick(); idle();
    beats(8);
    chk("R8 zero cancels fetch", {31'b0, buf_valid}, 0);

    touch(32'h2000_0400, 0, 1, 0, 0, 0);
    chk("R2 translation miss", {31'b0, fetch_req}, 0);
    touch(32'h2000_0400, 1, 0, 0, 0, 0);
    chk("R2 no load permission", {31'b0, fetch_req}, 0);
    beats(8);
    chk("R2 buffer stays invalid", {31'b0, buf_valid}, 0);
    touch(32'h2000_0400, 1, 1, 1, 0, 0);
    chk("R3 guarded", {31'b0, fetch_req}, 0);
    touch(32'h2000_0400, 1, 1, 0, 1, 0);
    chk("R3 locked", {31'b0, fetch_req}, 0);
    touch(32'h2000_0400, 1, 1, 0, 0, 1);
    chk("R3 disabled", {31'b0, fetch_req}, 0);
    beats(8);
    chk("R3 buffer stays invalid", {31'b0, buf_valid}, 0);

    fill(32'h2000_0500);
    touch(32'h2000_0500, 0, 1, 0, 0, 0);
    chk("R9 refused touch discards buffer", {31'b0, buf_valid}, 0);
    touch(32'h2000_0600, 1, 1, 0, 0, 0);
    beats(4);
    touch(32'h2000_0700, 1, 1, 0, 0, 0);
    chk("R9 new request", fetch_addr, 32'h2000_0700);
    beats(4);
    chk("R9 old beats do not count", {31'b0, buf_valid}, 0);
    beats(4);
    chk("R9 replacement line valid", {31'b0, buf_valid}, 1);
    chk("R9 replacement address", buf_addr, 32'h2000_0700);
    touch_req = 1; touch_addr = 32'h2000_0800; cmo_req = 1; tick(); idle();
    chk("R9 touch wins over cmo", {31'b0, fetch_req}, 1);
    beats(8);
    chk("R9 touch after cmo completes", {31'b0, buf_valid}, 1);

    for (int i = 0; i < 4000; i++) begin
      idle();
      touch_req      = ($urandom % 12) == 0;
      touch_addr     = 32'h3000_0000 + (($urandom % 4) << 5) + ($urandom % 32);
      xlat_hit       = ($urandom % 8) != 0;
      load_ok        = ($urandom % 8) != 0;
      guarded        = ($urandom % 10) == 0;
      cache_locked   = ($urandom % 12) == 0;
      cache_disabled = ($urandom % 12) == 0;
      fill_beat      = ($urandom % 2) == 0;
      cmo_req        = ($urandom % 40) == 0;
      moved          = ($urandom % 10) == 0;
      zero_req       = ($urandom % 25) == 0;
      zero_addr      = 32'h3000_0000 + (($urandom % 4) << 5) + ($urandom % 32);
      tick();
    end
    idle();
    tick();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule